// File: doc/BRIEF.md
# Xon/Xoff Software Flow Control Engine

This block sits between a UART receiver and its receive FIFO and also gates the local transmitter. Each received character is compared against programmed resume and stop codes. A stop match halts the transmitter at the next character boundary, sets a sticky stop flag and can raise an interrupt. A later resume match lets the transmitter run again and clears the flag. Characters that make up a matched code never reach the FIFO. All other characters are passed on with one cycle of latency.

A two-bit mode input selects the matching scheme. In the off mode every character passes through and the transmitter is never held. In single mode one character is compared. In pair mode two consecutive characters must both match. In pair mode a first character that matches is held back until the next character arrives. If that next character does not complete the pair, the held character is released first, and the newcomer is then judged as a possible new first character.

The receiver is expected to present characters at least two clock cycles apart. Serial framing and baud timing belong to the neighbouring blocks. The mode and code inputs are expected to stay stable while characters are arriving.

Top module: `xonxoff_flow`

## Requirements
- R1: After reset, fifo_wr is 0, tx_permit is 1, stop_flag is 0 and irq is 0.
- R2: When mode is 2'b00 or 2'b11 (off), every received character is written to the FIFO in order, one cycle after its rx_valid, and tx_permit stays 1.
- R3: When mode is 2'b01 (single), a character equal to stop_c1 is not written and sets stop_flag.
- R4: After a stop match, tx_permit falls on the first clock edge at which tx_busy is 0 or tx_char_done is 1. This means one cycle after the match when the transmitter is idle, and one cycle after tx_char_done when it is mid-character.
- R5: irq equals stop_flag gated by irq_en.
- R6: While the transmitter is halted or a halt is pending, a character equal to go_c1 (single mode) is not written, raises tx_permit on the next cycle and clears stop_flag. When the transmitter is not halted, such a character passes through as data.
- R7: When mode is 2'b10 (pair), stop_c1 followed by stop_c2 counts as a stop match, and go_c1 followed by go_c2 counts as a resume match (only while halted). Neither character of a matched pair is written.
- R8: In pair mode, when a held first character is followed by a non-completing character, the held character is written first and the newcomer is written one cycle later. If the newcomer is itself a first character, it is held instead of written.
- R9: A one-cycle stat_rd clears stop_flag (and hence irq) without resuming the transmitter. A stop match in the same cycle takes precedence and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00/11 off, 01 single, 10 pair |
| go_c1 | input | 8 | First resume code |
| go_c2 | input | 8 | Second resume code (pair mode) |
| stop_c1 | input | 8 | First stop code |
| stop_c2 | input | 8 | Second stop code (pair mode) |
| irq_en | input | 1 | Interrupt enable for the stop flag |
| stat_rd | input | 1 | Host status read, clears stop flag |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_char_done | input | 1 | Transmitter finished a character |
| fifo_wr | output | 1 | Receive FIFO write enable |
| fifo_data | output | 8 | Receive FIFO write data |
| tx_permit | output | 1 | Transmitter may start characters |
| stop_flag | output | 1 | Sticky stop-match status |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets a pair-mode first character followed by a non-completing character. A design that drops the held byte, or writes the two bytes out of order, leaves the scoreboard short or mismatched. It also sends a repeated first stop code before its second code. A design that does not re-arm on the newcomer misses the stop, and one that re-arms wrongly writes the byte twice. It holds the transmitter busy across a stop match: a design that halts immediately drops tx_permit before tx_char_done. It also sends a resume code while the transmitter is running, which must pass through as data, and lands a status read in the same cycle as a stop match, where a wrong priority clears the flag.

// File: rtl/xonxoff_flow.sv
module xonxoff_flow #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] go_c1,
  input  logic [DW-1:0] go_c2,
  input  logic [DW-1:0] stop_c1,
  input  logic [DW-1:0] stop_c2,
  input  logic          irq_en,
  input  logic          stat_rd,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          tx_busy,
  input  logic          tx_char_done,
  output logic          fifo_wr,
  output logic [DW-1:0] fifo_data,
  output logic          tx_permit,
  output logic          stop_flag,
  output logic          irq
);
  localparam logic [1:0] M_ONE = 2'b01;
  localparam logic [1:0] M_TWO = 2'b10;

  logic          hold_v, hold_stop, pend_v, stop_pend, halted;
  logic [DW-1:0] hold_d, pend_d;
  logic          m_stop, m_go, w, p_set, h_set, h_clr, h_stop;
  logic [DW-1:0] wd;

  wire single   = (mode == M_ONE);
  wire pair     = (mode == M_TWO);
  wire on       = single | pair;
  wire watch_go = stop_pend | halted;
  wire is_stop1 = (rx_data == stop_c1);
  wire is_go1   = watch_go && (rx_data == go_c1);
  wire sec_hit  = hold_v && (hold_stop ? (rx_data == stop_c2) : (rx_data == go_c2));

  always_comb begin
    m_stop = 1'b0; m_go = 1'b0; w = 1'b0; wd = rx_data;
    p_set = 1'b0; h_set = 1'b0; h_clr = 1'b0; h_stop = 1'b0;
    if (rx_valid) begin
      if (!on) w = 1'b1;
      else if (single) begin
        if (is_stop1)    m_stop = 1'b1;
        else if (is_go1) m_go = 1'b1;
        else             w = 1'b1;
      end else if (sec_hit) begin
        m_stop = hold_stop;
        m_go   = !hold_stop;
        h_clr  = 1'b1;
      end else begin
        if (hold_v) begin w = 1'b1; wd = hold_d; end
        if (is_stop1 || is_go1) begin
          h_set  = 1'b1;
          h_stop = is_stop1;
        end else begin
          h_clr = 1'b1;
          if (hold_v) p_set = 1'b1;
          else        w = 1'b1;
        end
      end
    end else if (pend_v) begin
      w = 1'b1; wd = pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_wr <= 1'b0; fifo_data <= '0;
      pend_v <= 1'b0; pend_d <= '0;
      hold_v <= 1'b0; hold_d <= '0; hold_stop <= 1'b0;
      stop_pend <= 1'b0; halted <= 1'b0; stop_flag <= 1'b0;
    end else begin
      fifo_wr   <= w;
      fifo_data <= wd;
      pend_v    <= p_set;
      pend_d    <= rx_data;
      if (!pair) hold_v <= 1'b0;
      else if (h_set) begin
        hold_v <= 1'b1; hold_d <= rx_data; hold_stop <= h_stop;
      end else if (h_clr) hold_v <= 1'b0;
      if (!on) begin
        stop_pend <= 1'b0; halted <= 1'b0;
      end else if (m_go) begin
        stop_pend <= 1'b0; halted <= 1'b0;
      end else begin
        if (m_stop && !halted) stop_pend <= 1'b1;
        if (stop_pend && (!tx_busy || tx_char_done)) begin
          stop_pend <= 1'b0; halted <= 1'b1;
        end
      end
      if (!on)                stop_flag <= 1'b0;
      else if (m_stop)        stop_flag <= 1'b1;
      else if (m_go || stat_rd) stop_flag <= 1'b0;
    end
  end

  assign tx_permit = !halted;
  assign irq       = stop_flag & irq_en;

  a_r2_permit_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> tx_permit);
  a_r4_halt_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_permit) |-> $past(!tx_busy || tx_char_done));
  a_r3_flag_from_rx: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_flag) |-> $past(rx_valid));
  a_r6_resume_from_rx: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_permit) |-> $past(rx_valid || !on));
  a_r9_flag_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_flag) |-> $past(stat_rd || rx_valid || !on));
  a_r8_rx_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r8_write_source: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> $past(rx_valid || pend_v));
endmodule

// File: tb/xonxoff_flow_tb.sv
module xonxoff_flow_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0;
  logic [7:0] go_c1 = 8'h11, go_c2 = 8'h91, stop_c1 = 8'h13, stop_c2 = 8'h93;
  logic irq_en = 0, stat_rd = 0, rx_valid = 0, tx_busy = 0, tx_char_done = 0;
  logic [7:0] rx_data = 0;
  logic fifo_wr, tx_permit, stop_flag, irq;
  logic [7:0] fifo_data;
  int checks = 0, fails = 0;
  logic [7:0] q[$];
  string tag = "R2";

  always #4 clk = ~clk;

  xonxoff_flow u_dut (.clk(clk), .rst_n(rst_n), .mode(mode), .go_c1(go_c1),
    .go_c2(go_c2), .stop_c1(stop_c1), .stop_c2(stop_c2), .irq_en(irq_en),
    .stat_rd(stat_rd), .rx_valid(rx_valid), .rx_data(rx_data), .tx_busy(tx_busy),
    .tx_char_done(tx_char_done), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
    .tx_permit(tx_permit), .stop_flag(stop_flag), .irq(irq));

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", t, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(negedge clk) if (rst_n && fifo_wr) begin
    if (q.size() == 0) chk({tag, " unexpected write"}, {24'h0, fifo_data}, 32'hFFFF);
    else chk({tag, " fifo data"}, {24'h0, fifo_data}, {24'h0, q.pop_front()});
  end

  task automatic send(logic [7:0] d, bit exp, bit rd = 0);
    @(negedge clk);
    rx_valid = 1; rx_data = d; stat_rd = rd;
    if (exp) q.push_back(d);
    @(negedge clk);
    rx_valid = 0; stat_rd = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 fifo_wr", fifo_wr, 0); chk("R1 permit", tx_permit, 1);
    chk("R1 flag", stop_flag, 0);  chk("R1 irq", irq, 0);
    rst_n = 1;
    tag = "R2";
    send(8'h13, 1); send(8'h41, 1);
    mode = 2'b11; send(8'h13, 1);
    chk("R2 permit off", tx_permit, 1); chk("R2 flag off", stop_flag, 0);

    mode = 2'b01; irq_en = 1; tag = "R6";
    send(8'h11, 1); send(8'h41, 1);
    chk("R6 permit unhalted", tx_permit, 1);
    tag = "R3"; send(8'h13, 0);
    chk("R3 flag", stop_flag, 1); chk("R5 irq on", irq, 1);
    chk("R4 permit idle", tx_permit, 0);
    send(8'h42, 1);
    tag = "R6"; send(8'h11, 0);
    chk("R6 permit", tx_permit, 1); chk("R6 flag", stop_flag, 0); chk("R5 irq off", irq, 0);

    irq_en = 0; tag = "R5"; send(8'h13, 0);
    chk("R5 flag", stop_flag, 1); chk("R5 irq masked", irq, 0);
    @(negedge clk) stat_rd = 1; @(negedge clk) stat_rd = 0;
    chk("R9 read clears", stop_flag, 0); chk("R9 still halted", tx_permit, 0);
    send(8'h11, 0); chk("R9 resume", tx_permit, 1);

    tx_busy = 1; tag = "R4"; send(8'h13, 0);
    chk("R4 busy keeps permit", tx_permit, 1);
    @(negedge clk) tx_char_done = 1; @(negedge clk) tx_char_done = 0;
    chk("R4 halt after done", tx_permit, 0);
    tx_busy = 0; send(8'h11, 0);
    tag = "R9"; send(8'h13, 0, 1);
    chk("R9 match beats read", stop_flag, 1);
    send(8'h11, 0);

    mode = 2'b10; tag = "R8";
    send(8'h13, 1); send(8'h41, 1);
    chk("R8 no halt", tx_permit, 1);
    tag = "R7"; send(8'h13, 0); send(8'h93, 0);
    chk("R7 flag", stop_flag, 1); chk("R7 halted", tx_permit, 0);
    tag = "R8"; send(8'h11, 1); send(8'h41, 1);
    chk("R8 still halted", tx_permit, 0);
    tag = "R7"; send(8'h11, 0); send(8'h91, 0);
    chk("R7 resume", tx_permit, 1); chk("R7 flag clr", stop_flag, 0);
    tag = "R8"; send(8'h13, 1); send(8'h13, 0); send(8'h93, 0);
    chk("R8 rearm halt", tx_permit, 0); chk("R8 rearm flag", stop_flag, 1);
    send(8'h11, 0); send(8'h91, 0);
    chk("R8 resume", tx_permit, 1);
    repeat (4) @(negedge clk);
    chk("R2 all expected written", q.size(), 0);
    finish_run();
  end
endmodule